// File: doc/BRIEF.md
# Line-Level Validity Detector

This block watches a group of serial-line receiver channels and reports, on one active-low output, whether any usable line signal is present. Each channel supplies a signed sample of its line voltage, counted in tenths of a volt. All channels are sampled together and offered on one bus with a single strobe. Each sample is sorted into one of three zones. A large magnitude is a good level. A magnitude near zero is a dead level. The band between them is a grey zone, and a sample there leaves that channel's earlier verdict in place.

The output changes only after a condition has lasted for a set time, and the two directions use different times. It falls only after every channel has been dead for a long stretch, such as the state left by a detached cable whose inputs are pulled to ground. It rises again after a short stretch during which at least one channel shows a good level. Both stretches are parameters in clock cycles. The output is purely a report: the block drives no power control of its own, and it keeps working whatever power state the surrounding logic has chosen.

The sample bus carries only a strobe. The block accepts a sample set on every cycle in which the strobe is high and never applies back-pressure, so no ready signal exists.

Top module: `line_validity_det`

## Requirements
- R1: While reset is held and directly after it is released, `lines_dead_n` is 1 and every channel is treated as good.
- R2: A strobed sample whose magnitude is at least `GOOD_MIN` (tenths of a volt) marks that channel good, for either sign, and this includes the most negative code the sample width can hold.
- R3: A strobed sample whose magnitude is at most `DEAD_MAX` marks that channel dead, for either sign. An all-zero sample is therefore dead.
- R4: A strobed sample whose magnitude lies strictly between `DEAD_MAX` and `GOOD_MIN` leaves that channel's verdict unchanged.
- R5: Suppose a strobed sample set is captured at clock edge E and leaves every channel dead, and every channel stays dead from then on. Then `lines_dead_n` is still 1 after edge E+FALL_CYC-1 and is 0 after edge E+FALL_CYC.
- R6: If any channel turns good while the fall window is running, the window is discarded. The full FALL_CYC count starts again only once every channel is dead again.
- R7: While `lines_dead_n` is 0, suppose a sample set captured at edge E leaves at least one channel good and the set of good channels stays non-empty. Then the output is 1 after edge E+RISE_CYC. If every channel becomes dead before that, the rise count is discarded.
- R8: Sample data presented while `smp_valid` is 0 changes no channel verdict and so has no effect on `lines_dead_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: the sample set on `smp_data` is captured this cycle |
| smp_data | input | NCH*SW | Channel samples, channel k in bits [k*SW +: SW], two's complement, tenths of a volt |
| lines_dead_n | output | 1 | 0 when no channel has shown a good level for the fall time |

## Verification
The hardest situation to reach is a fall window that is partly consumed and then interrupted. To reach it, a single good sample is injected in the middle of an all-dead stretch. Grey-zone samples are then fed on every channel, so the window has to keep running because each channel holds its dead verdict. The same approach is used on the rising side: a good level shorter than the rise time is shown, and the bench confirms that the output stays low and that the rise count begins again from zero. A scoreboard advances a requirement-level model for every clock cycle, so an off-by-one in either window is caught at the exact edge where it happens.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  typedef enum logic {
    LVD_SIGNAL = 1'b1,
    LVD_SILENT = 1'b0
  } lvd_state_e;

  function automatic int lvd_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lvd_chan_class.sv
module lvd_chan_class #(
  parameter int SW       = 9,
  parameter int GOOD_MIN = 27,
  parameter int DEAD_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_in,
  output logic          good_q
);
  localparam int MW = SW + 1;

  logic signed [MW-1:0] ext;
  logic        [MW-1:0] mag;
  logic                 zone_good;
  logic                 zone_dead;

  // one extra bit keeps the most negative code representable after negation
  assign ext       = {smp_in[SW-1], smp_in};
  assign mag       = ext[MW-1] ? MW'(-ext) : MW'(ext);
  assign zone_good = (mag >= MW'(GOOD_MIN));
  assign zone_dead = (mag <= MW'(DEAD_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b1;
    end else if (smp_valid) begin
      if (zone_good)      good_q <= 1'b1;
      else if (zone_dead) good_q <= 1'b0;
    end
  end

  p_good_zone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && zone_good) |=> good_q);
  p_dead_zone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && zone_dead) |=> !good_q);
  p_grey_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !zone_good && !zone_dead) |=> $stable(good_q));
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(good_q));
endmodule

// File: rtl/lvd_persist.sv
module lvd_persist #(
  parameter int FALL_CYC = 1500,
  parameter int RISE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_dead,
  output logic flag_n
);
  import lvd_pkg::*;

  localparam int MAXC = lvd_max(FALL_CYC, RISE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  lvd_state_e    state_q;
  logic [CW-1:0] run_q;
  logic          toward;

  // the condition that pushes toward the other state
  assign toward = (state_q == LVD_SIGNAL) ? all_dead : !all_dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LVD_SIGNAL;
      run_q   <= '0;
    end else if (!toward) begin
      run_q <= '0;
    end else if (state_q == LVD_SIGNAL && run_q == CW'(FALL_CYC - 1)) begin
      state_q <= LVD_SILENT;
      run_q   <= '0;
    end else if (state_q == LVD_SILENT && run_q == CW'(RISE_CYC - 1)) begin
      state_q <= LVD_SIGNAL;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign flag_n = (state_q == LVD_SIGNAL);

  p_fall_needs_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_n) |-> $past(all_dead));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_n && !all_dead) |=> (run_q == '0));
  p_rise_needs_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_n) |-> $past(!all_dead));
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(MAXC));
endmodule

// File: rtl/line_validity_det.sv
module line_validity_det #(
  parameter int NCH      = 5,
  parameter int SW       = 9,
  parameter int GOOD_MIN = 27,
  parameter int DEAD_MAX = 3,
  parameter int FALL_CYC = 1500,
  parameter int RISE_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [NCH*SW-1:0] smp_data,
  output logic              lines_dead_n
);
  logic [NCH-1:0] chan_good;
  logic           all_dead;

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    lvd_chan_class #(
      .SW      (SW),
      .GOOD_MIN(GOOD_MIN),
      .DEAD_MAX(DEAD_MAX)
    ) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .smp_in   (smp_data[k*SW +: SW]),
      .good_q   (chan_good[k])
    );
  end

  assign all_dead = ~|chan_good;

  lvd_persist #(
    .FALL_CYC(FALL_CYC),
    .RISE_CYC(RISE_CYC)
  ) u_persist (
    .clk     (clk),
    .rst_n   (rst_n),
    .all_dead(all_dead),
    .flag_n  (lines_dead_n)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (lines_dead_n && (&chan_good)));
endmodule

// File: tb/line_validity_det_tb_top.sv
module line_validity_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int SW  = 9;
  localparam int GMIN = 27;
  localparam int DMAX = 3;
  localparam int FALL = 20;
  localparam int RISE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic              lines_dead_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct { logic val; string tag; } exp_t;
  exp_t exp_q[$];

  // requirement-level model state
  bit m_good [NCH];
  bit m_out;
  int m_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_validity_det #(
    .NCH(NCH), .SW(SW), .GOOD_MIN(GMIN), .DEAD_MAX(DMAX),
    .FALL_CYC(FALL), .RISE_CYC(RISE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_data(smp_data), .lines_dead_n(lines_dead_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: lines_dead_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic v, input int s0, input int s1, input int s2);
    int smp [NCH];
    bit any_good;
    smp[0] = s0; smp[1] = s1; smp[2] = s2;
    any_good = 0;
    for (int k = 0; k < NCH; k++) any_good |= m_good[k];
    if (m_out) begin
      if (!any_good) begin
        m_run++;
        if (m_run == FALL) begin m_out = 0; m_run = 0; end
      end else m_run = 0;
    end else begin
      if (any_good) begin
        m_run++;
        if (m_run == RISE) begin m_out = 1; m_run = 0; end
      end else m_run = 0;
    end
    if (v) begin
      for (int k = 0; k < NCH; k++) begin
        int a;
        a = (smp[k] < 0) ? -smp[k] : smp[k];
        if (a >= GMIN) m_good[k] = 1;
        else if (a <= DMAX) m_good[k] = 0;
      end
    end
  endtask

  // driver: presents a sample set for n cycles and queues the expected output
  task automatic step(input logic v, input int s0, input int s1, input int s2,
                      input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = v;
      smp_data  = {SW'(s2), SW'(s1), SW'(s0)};
      @(posedge clk);
      model_edge(v, s0, s1, s2);
      exp_q.push_back('{m_out, tag});
    end
  endtask

  // monitor: compares each produced output against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(lines_dead_n, e.val, e.tag);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) m_good[k] = 1;
    m_out = 1; m_run = 0;
    #(CLK_PERIOD*3);
    check(lines_dead_n, 1'b1, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    check(lines_dead_n, 1'b1, "R1 after reset");
    // good levels of both signs, all channels
    step(1, 30, -30, 100, 5, "R2 good levels");
    // detached cable: all inputs at ground, output falls after FALL edges
    step(1, 0, 0, 0, FALL + 4, "R3 R5 dead fall");
    // short good burst below the rise time, then dead again: stays low
    step(1, 0, 40, 0, 2, "R7 short good");
    step(1, 0, 0, 0, 6, "R7 rise restart");
    // boundary good value brings the output back up
    step(1, GMIN, 0, 0, RISE + 3, "R2 R7 boundary rise");
    // boundary dead values, then an interrupting good sample mid-window
    step(1, DMAX, -DMAX, 0, 10, "R3 boundary dead");
    step(1, 0, -GMIN, 0, 1, "R6 interrupt");
    step(1, 0, 0, 0, 1, "R6 redead");
    // grey-zone values keep every channel dead: window must complete
    step(1, 15, -20, DMAX + 1, FALL + 3, "R4 R6 grey hold dead");
    // strobe low with good data: nothing changes
    step(0, 50, 50, 50, 8, "R8 no strobe");
    // good then grey: channel stays good, output rises and stays up
    step(1, 0, 0, -256, RISE + 2, "R2 full scale negative");
    step(1, 0, 0, -(GMIN - 1), FALL + 5, "R4 grey hold good");
    step(1, 0, 0, 0, 2, "R3 final dead");
    @(negedge clk);
    done = 1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end
endmodule